// File: doc/BRIEF.md
# SDRAM Deep Power-Down Sequencer

This block sits on the controller side of an SDRAM command bus. It drives the clock-enable, chip-select and the three strobe lines so that the memory can be moved into its lowest-power state, in which the whole array loses power, and later brought back. The host raises a power-down request while the sequencer reports ready. The host also supplies a flag that shows whether any bank is still open. If a bank is open, the sequencer first closes every bank with a precharge-all command and waits the row-precharge time. It then sends the entry command, which is sampled on the same edge as clock-enable going low.

While the memory is powered down, clock-enable stays low and the bus carries only NOP commands. A wake request raises clock-enable again. Because the array contents are gone, the wake is followed by a complete re-initialization before the sequencer reports ready:

1. a programmable stabilization wait filled with NOPs;
2. a precharge-all command;
3. two auto-refresh commands;
4. a mode register set.

A data-lost flag tells the host that memory contents must be treated as invalid. The flag stays set until the host clears it.

All timing limits are parameters in clock cycles, and one down-counter times every wait. The parameters are the stabilization wait (at least 1) and the row-precharge, row-cycle and mode-register-set times (each at least 2).

Top module: `sdram_dpd_seq`

## Requirements
- R1: During and right after reset, ready=1, busy=0, cke=1, cs_n=1 (deselect) and data_lost=0.
- R2: pd_req sampled while ready, with bank_open=1, puts a precharge-all on the bus in the next cycle. That command is cs_n,ras_n,cas_n,we_n = 0,0,1,0 with a10=1. The entry command follows exactly T_RP cycles after the precharge, and NOPs fill the gap. With bank_open=0, the entry command appears in the cycle right after the request.
- R3: The entry cycle has cke=0 after a cycle with cke=1, and carries cs_n,ras_n,cas_n,we_n = 0,1,1,0.
- R4: In every cycle after the entry cycle until the wake, cke=0 and the bus carries NOP (0,1,1,1).
- R5: A wake_req sampled while powered down gives, in the next cycle, cke=1 with NOP, while busy stays high. A wake_req sampled during the precharge, the tRP wait or the entry cycle is held and then serviced, so the wake edge comes two cycles after the entry cycle.
- R6: After the wake edge come T_STAB NOP cycles and then the re-initialization commands, with NOPs in between:
  - precharge-all;
  - T_RP cycles later, auto-refresh (0,0,0,1);
  - T_RC cycles later, a second auto-refresh;
  - T_RC cycles later, mode register set (0,0,0,0);
  - T_MRD cycles after the mode register set, ready rises.
- R7: busy is the inverse of ready. It is high in every cycle from the first sequence cycle until ready returns. While ready, the bus is deselected (cs_n=1, the other strobes high, a10=0).
- R8: pd_req is ignored while not ready, and the command stream is unchanged by it.
- R9: data_lost rises in the cycle after the entry cycle and holds until lost_clr is sampled high. It then falls in the next cycle. If lost_clr is high during the entry cycle, setting takes priority.
- R10: wake_req while ready, or during re-initialization, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Power-down request, accepted only while ready |
| wake_req | input | 1 | Wake request |
| bank_open | input | 1 | High when any bank is open |
| lost_clr | input | 1 | Clears data_lost |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | All-banks select for precharge |
| ready | output | 1 | Idle and initialized |
| busy | output | 1 | Sequence in progress |
| data_lost | output | 1 | Array contents lost since last clear |

## Verification
Every output depends directly on the state register and the init step register. A wrong state or step therefore shows up on the command pins, cke or ready in the very cycle it occurs. A counter that is loaded one value off does not show as a wrong command. It shows as a command that arrives one cycle early or late, and the per-cycle comparison catches it at the first misplaced command. A lost held wake or a missed data-lost update shows up within one cycle of the event that should have caused it.

// File: rtl/sdram_dpd_seq.sv
module sdram_dpd_seq #(
  parameter int T_STAB = 200,
  parameter int T_RP   = 3,
  parameter int T_RC   = 7,
  parameter int T_MRD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic wake_req,
  input  logic bank_open,
  input  logic lost_clr,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10,
  output logic ready,
  output logic busy,
  output logic data_lost
);

  localparam int M1    = (T_STAB > T_RP) ? T_STAB : T_RP;
  localparam int M2    = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_MRS   = 4'b0000;
  localparam logic [3:0] C_DPD   = 4'b0110;

  typedef enum logic [2:0] {
    S_READY, S_PRECHARGE, S_WAIT_TRP, S_ENTER, S_DPD, S_EXIT, S_INIT
  } state_t;

  typedef enum logic [3:0] {
    I_STAB, I_PRE, I_WRP, I_REF1, I_WRC1, I_REF2, I_WRC2, I_MRS, I_WMRD
  } step_t;

  state_t           state;
  step_t            step;
  logic [CNT_W-1:0] cnt;
  logic             wake_pend;
  logic [3:0]       cmd;
  logic             cnt_done;

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_READY;
      step      <= I_STAB;
      cnt       <= '0;
      wake_pend <= 1'b0;
      data_lost <= 1'b0;
    end else begin
      case (state)
        S_READY:
          if (pd_req) state <= bank_open ? S_PRECHARGE : S_ENTER;
        S_PRECHARGE: begin
          state <= S_WAIT_TRP;
          cnt   <= CNT_W'(T_RP - 2);
        end
        S_WAIT_TRP:
          if (cnt_done) state <= S_ENTER;
          else          cnt   <= cnt - 1'b1;
        S_ENTER:
          state <= S_DPD;
        S_DPD:
          if (wake_pend || wake_req) state <= S_EXIT;
        S_EXIT: begin
          state <= S_INIT;
          step  <= I_STAB;
          cnt   <= CNT_W'(T_STAB - 1);
        end
        S_INIT:
          case (step)
            I_STAB:
              if (cnt_done) step <= I_PRE;
              else          cnt  <= cnt - 1'b1;
            I_PRE: begin
              step <= I_WRP;
              cnt  <= CNT_W'(T_RP - 2);
            end
            I_WRP:
              if (cnt_done) step <= I_REF1;
              else          cnt  <= cnt - 1'b1;
            I_REF1: begin
              step <= I_WRC1;
              cnt  <= CNT_W'(T_RC - 2);
            end
            I_WRC1:
              if (cnt_done) step <= I_REF2;
              else          cnt  <= cnt - 1'b1;
            I_REF2: begin
              step <= I_WRC2;
              cnt  <= CNT_W'(T_RC - 2);
            end
            I_WRC2:
              if (cnt_done) step <= I_MRS;
              else          cnt  <= cnt - 1'b1;
            I_MRS: begin
              step <= I_WMRD;
              cnt  <= CNT_W'(T_MRD - 2);
            end
            I_WMRD:
              if (cnt_done) begin
                step  <= I_STAB;
                state <= S_READY;
              end else begin
                cnt <= cnt - 1'b1;
              end
            default: step <= I_STAB;
          endcase
        default: state <= S_READY;
      endcase

      if (state == S_DPD)
        wake_pend <= 1'b0;
      else if (wake_req && (state == S_PRECHARGE || state == S_WAIT_TRP || state == S_ENTER))
        wake_pend <= 1'b1;

      if (state == S_ENTER) data_lost <= 1'b1;
      else if (lost_clr)    data_lost <= 1'b0;
    end
  end

  always_comb begin
    cmd = C_NOP;
    a10 = 1'b0;
    cke = 1'b1;
    case (state)
      S_READY:     cmd = C_DESEL;
      S_PRECHARGE: begin cmd = C_PRE; a10 = 1'b1; end
      S_ENTER:     begin cmd = C_DPD; cke = 1'b0; end
      S_DPD:       cke = 1'b0;
      S_INIT:
        case (step)
          I_PRE:          begin cmd = C_PRE; a10 = 1'b1; end
          I_REF1, I_REF2: cmd = C_REF;
          I_MRS:          cmd = C_MRS;
          default:        cmd = C_NOP;
        endcase
      default:     cmd = C_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ready = (state == S_READY);
  assign busy  = ~ready;

  AST_ENTRY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0110)); // R3
  AST_ENTRY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(state) == S_WAIT_TRP || ($past(state) == S_READY && !$past(bank_open)))); // R2
  AST_DPD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R4
  AST_EXIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (busy && {cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R5
  AST_LOST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> data_lost); // R9

endmodule

// File: tb/sdram_dpd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_dpd_seq_tb_top;

  localparam int T_STAB = 6;
  localparam int T_RP   = 3;
  localparam int T_RC   = 5;
  localparam int T_MRD  = 2;

  localparam int M_IDLE = 0, M_ENT = 1, M_DPD = 2, M_INIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, wake_req = 1'b0, bank_open = 1'b0, lost_clr = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, ready, busy, data_lost;

  always #2 clk = ~clk;

  sdram_dpd_seq #(.T_STAB(T_STAB), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
    .bank_open(bank_open), .lost_clr(lost_clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10), .ready(ready),
    .busy(busy), .data_lost(data_lost));

  typedef struct {
    logic       cke;
    logic [3:0] cmd;
    logic       a10;
    logic       rdy;
    int         mode;
    string      tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    nchk = 0, nerr = 0, k = 0;
  logic  m_lost = 1'b0, pend = 1'b0;
  logic  prev_cke = 1'b1, prev_rdy = 1'b1, in_init = 1'b0, entry_pre = 1'b0;
  int    pre_k = 0, rise_k = 0;
  logic [3:0] seen_cmd[$];
  int         seen_k[$];

  function automatic item_t mk(logic c, logic [3:0] cm, logic a, logic r, int m, string t);
    item_t it;
    it.cke = c; it.cmd = cm; it.a10 = a; it.rdy = r; it.mode = m; it.tag = t;
    return it;
  endfunction

  task automatic chk(logic ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_nops(int n, int m, string t);
    for (int i = 0; i < n; i++) q.push_back(mk(1'b1, 4'b0111, 1'b0, 1'b0, m, t));
  endtask

  task automatic cyc(logic pd, logic wk, logic bo, logic clr);
    item_t nx;
    logic  lost_nx;
    logic [3:0] gc;
    @(negedge clk);
    k++;
    gc = {cs_n, ras_n, cas_n, we_n};
    chk({cke, gc, a10, ready, busy} === {cur.cke, cur.cmd, cur.a10, cur.rdy, ~cur.rdy},
        cur.tag, "pins{cke,cmd,a10,rdy,busy}",
        int'({cke, gc, a10, ready, busy}), int'({cur.cke, cur.cmd, cur.a10, cur.rdy, ~cur.rdy}));
    chk(data_lost === m_lost, "R9", "data_lost", int'(data_lost), int'(m_lost));

    if (gc == 4'b0010 && cke && !ready && !in_init) begin entry_pre = 1'b1; pre_k = k; end
    if (prev_cke && !cke) begin
      chk(gc == 4'b0110, "R3", "entry pins", int'(gc), 6);
      if (entry_pre) chk(k - pre_k == T_RP, "R2", "tRP gap", k - pre_k, T_RP);
      entry_pre = 1'b0;
    end
    if (!prev_cke && cke) begin
      chk(gc == 4'b0111 && !ready, "R5", "exit pins", int'({gc, ready}), 14);
      in_init = 1'b1; rise_k = k; seen_cmd.delete(); seen_k.delete();
    end else if (in_init && gc != 4'b0111 && !ready) begin
      seen_cmd.push_back(gc); seen_k.push_back(k);
    end
    if (in_init && ready && !prev_rdy) begin
      in_init = 1'b0;
      chk(seen_cmd.size() == 4, "R6", "init cmd count", seen_cmd.size(), 4);
      if (seen_cmd.size() == 4) begin
        chk({seen_cmd[0], seen_cmd[1], seen_cmd[2], seen_cmd[3]} == 16'h2110,
            "R6", "init order", int'({seen_cmd[0], seen_cmd[1], seen_cmd[2], seen_cmd[3]}), 16'h2110);
        chk(seen_k[0] - rise_k == T_STAB + 1, "R6", "stab wait", seen_k[0] - rise_k, T_STAB + 1);
        chk(seen_k[1] - seen_k[0] == T_RP, "R6", "tRP", seen_k[1] - seen_k[0], T_RP);
        chk(seen_k[2] - seen_k[1] == T_RC, "R6", "tRC 1", seen_k[2] - seen_k[1], T_RC);
        chk(seen_k[3] - seen_k[2] == T_RC, "R6", "tRC 2", seen_k[3] - seen_k[2], T_RC);
        chk(k - seen_k[3] == T_MRD, "R6", "tMRD", k - seen_k[3], T_MRD);
      end
    end
    prev_cke = cke; prev_rdy = ready;

    pd_req = pd; wake_req = wk; bank_open = bo; lost_clr = clr;

    if (cur.mode == M_IDLE && pd) begin
      if (bo) begin
        q.push_back(mk(1'b1, 4'b0010, 1'b1, 1'b0, M_ENT, "R2"));
        push_nops(T_RP - 1, M_ENT, "R2");
      end
      q.push_back(mk(1'b0, 4'b0110, 1'b0, 1'b0, M_ENT, "R3"));
    end
    if ((cur.mode == M_ENT || cur.mode == M_DPD) && wk) pend = 1'b1;
    if (cur.mode == M_DPD && pend) begin
      pend = 1'b0;
      push_nops(1 + T_STAB, M_INIT, "R5");
      q.push_back(mk(1'b1, 4'b0010, 1'b1, 1'b0, M_INIT, "R6"));
      push_nops(T_RP - 1, M_INIT, "R6");
      q.push_back(mk(1'b1, 4'b0001, 1'b0, 1'b0, M_INIT, "R6"));
      push_nops(T_RC - 1, M_INIT, "R6");
      q.push_back(mk(1'b1, 4'b0001, 1'b0, 1'b0, M_INIT, "R6"));
      push_nops(T_RC - 1, M_INIT, "R6");
      q.push_back(mk(1'b1, 4'b0000, 1'b0, 1'b0, M_INIT, "R6"));
      push_nops(T_MRD - 1, M_INIT, "R8");
    end
    lost_nx = (cur.mode == M_ENT && cur.cke == 1'b0) ? 1'b1 : (clr ? 1'b0 : m_lost);
    if (q.size() > 0) nx = q.pop_front();
    else if (cur.mode == M_IDLE || cur.mode == M_INIT) nx = mk(1'b1, 4'b1111, 1'b0, 1'b1, M_IDLE, "R7");
    else nx = mk(1'b0, 4'b0111, 1'b0, 1'b0, M_DPD, "R4");
    cur = nx;
    m_lost = lost_nx;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cur = mk(1'b1, 4'b1111, 1'b0, 1'b1, M_IDLE, "R1");
    repeat (3) @(negedge clk);
    chk({cke, cs_n, ready, busy, data_lost} === 5'b11100, "R1", "reset state",
        int'({cke, cs_n, ready, busy, data_lost}), 5'b11100);
    rst_n = 1'b1;
    idle(3);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);                       // R10: wake while ready
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    idle(2);
    // open bank: precharge, tRP, entry, long power-down, wake
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    idle(10);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b1, i % 4 == 1, 1'b0, 1'b0); // R8, R10
    idle(15);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);                       // R9 clear
    idle(3);
    // closed banks, wake during entry cycle, clear during entry (set wins)
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    idle(32);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);
    // open bank, wake held from the tRP wait
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    idle(35);
    finish_run();
  end

endmodule